// File: doc/BRIEF.md
# USB Frame Timing Counter

This block keeps frame time for a full-speed USB host controller. Software programs a frame length in bit times, together with a full-speed maximum packet size and a toggle flag. On every bit-time tick the block counts down the bit times left in the current frame. When the count runs out, the next tick starts a new frame. At that point the block reloads the length, advances a 16-bit frame number and pulses a start-of-frame strobe.

Two comparisons let a scheduler decide what to send. The first reports when the remaining time has dropped to the periodic-start level, so periodic traffic should win. The second reports whether enough of the frame is left to start a low-speed transaction. The toggle flag moves into the remaining-count view only when a reload takes the new length, so software can see when its change took effect. Counting runs only while the controller is in its operational state.

Top module: `usb_frame_timer`

## Requirements
- R1: While reset is high, the register views read as follows: interval 0x00002EDF (length 11999, packet size 0, toggle 0); periodic start, low-speed threshold, remaining count and frame number all 0. The pulses, `periodic_pri` and `ls_ok` are all low.
- R2: A write with `wr_sel`=0 stores the frame length from bits 13:0, the packet size from bits 30:16 and the toggle from bit 31. Bits 15:14 of the interval view read 0.
- R3: A write with `wr_sel`=1 stores the periodic-start level from bits 13:0, and a write with `wr_sel`=2 stores the low-speed threshold from bits 14:0. All other bits of those views read 0. A write with `wr_sel`=3 changes no register.
- R4: On a tick with a nonzero remaining count, the count drops by one. On a tick with a zero count, the count reloads from the frame length and bit 31 of the remaining view takes the interval toggle. Both changes are visible one clock after the tick. Bits 30:14 of the remaining view read 0.
- R5: On each reload the frame number increases by one (wrapping at 16 bits), and `sof_pulse` is high for exactly that one clock.
- R6: `fno_pulse` is high for one clock whenever bit 15 of the frame number changes. This happens on the steps 0x7FFF to 0x8000 and 0xFFFF to 0x0000, and on no other step.
- R7: One clock after the values settle, `periodic_pri` is high exactly when the remaining count is less than or equal to the periodic-start level.
- R8: One clock after the values settle, `ls_ok` is high exactly when the remaining count is greater than the low-speed threshold.
- R9: While `run_en` is low, ticks are ignored. The remaining count, the frame number and the pulses all hold.
- R10: Writing a new interval in the middle of a frame leaves the remaining count and its toggle unchanged until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Operational state; counting runs only while high |
| bit_tick | input | 1 | One-clock strobe per bit time |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 interval, 1 periodic start, 2 low-speed threshold, 3 none |
| wr_data | input | 32 | Write data |
| interval_rd | output | 32 | Interval register view |
| pstart_rd | output | 32 | Periodic-start register view |
| lsthr_rd | output | 32 | Low-speed threshold view |
| remain_rd | output | 32 | Remaining bit times (13:0) and applied toggle (31) |
| frame_num | output | 16 | Frame number |
| sof_pulse | output | 1 | Start-of-frame strobe |
| fno_pulse | output | 1 | Frame-number bit 15 change strobe |
| periodic_pri | output | 1 | Periodic traffic has priority |
| ls_ok | output | 1 | Low-speed transaction may start |

## Verification
The countdown is first run with isolated ticks across a short frame. This separates the decrement from the reload and shows that the toggle is applied only at a frame boundary. Ticks given while `run_en` is low, and an interval rewrite in mid-frame, show whether anything leaks into the count before a reload. A zero-length frame with one tick every clock walks the frame number through all 65536 values, which finds out whether the overflow strobe fires at only the two bit-15 transitions. Setting the periodic-start level equal to the low-speed threshold and stepping the count across that level tests both comparisons at the equal boundary, where `<=` and `>` behave differently.

// File: rtl/usb_frm_pkg.sv
package usb_frm_pkg;
  localparam int REG_W = 32;
  typedef enum logic [1:0] {
    SEL_INTERVAL = 2'd0,
    SEL_PSTART   = 2'd1,
    SEL_LSTHR    = 2'd2,
    SEL_NONE     = 2'd3
  } frm_sel_e;
endpackage

// File: rtl/frm_regs.sv
module frm_regs
  import usb_frm_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int MPS_W   = 15,
  parameter int LST_W   = 15,
  parameter int FI_INIT = 11999
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [CNT_W-1:0] fi,
  output logic [MPS_W-1:0] mps,
  output logic             tog,
  output logic [CNT_W-1:0] pstart,
  output logic [LST_W-1:0] lsthr
);
  localparam int MPS_LO = REG_W - 1 - MPS_W;

  logic unused_gap;
  assign unused_gap = ^wr_data[MPS_LO-1:CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      fi     <= CNT_W'(FI_INIT);
      mps    <= '0;
      tog    <= 1'b0;
      pstart <= '0;
      lsthr  <= '0;
    end else if (wr_en) begin
      case (frm_sel_e'(wr_sel))
        SEL_INTERVAL: begin
          fi  <= wr_data[CNT_W-1:0];
          mps <= wr_data[REG_W-2:MPS_LO];
          tog <= wr_data[REG_W-1];
        end
        SEL_PSTART: pstart <= wr_data[CNT_W-1:0];
        SEL_LSTHR:  lsthr  <= wr_data[LST_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/frm_count.sv
module frm_count #(
  parameter int CNT_W = 14,
  parameter int NUM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] fi,
  input  logic             tog,
  output logic [CNT_W-1:0] remain,
  output logic             rem_tog,
  output logic [NUM_W-1:0] fnum,
  output logic             sof,
  output logic             fno
);
  logic             adv;
  logic [NUM_W-1:0] fnum_inc;

  assign adv      = run_en & bit_tick;
  assign fnum_inc = fnum + NUM_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      rem_tog <= 1'b0;
      fnum    <= '0;
      sof     <= 1'b0;
      fno     <= 1'b0;
    end else begin
      sof <= 1'b0;
      fno <= 1'b0;
      if (adv) begin
        if (remain == '0) begin
          remain  <= fi;
          rem_tog <= tog;
          fnum    <= fnum_inc;
          sof     <= 1'b1;
          fno     <= fnum_inc[NUM_W-1] ^ fnum[NUM_W-1];
        end else begin
          remain <= remain - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/frm_cmp.sv
module frm_cmp #(
  parameter int CNT_W = 14,
  parameter int LST_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] remain,
  input  logic [CNT_W-1:0] pstart,
  input  logic [LST_W-1:0] lsthr,
  output logic             periodic_pri,
  output logic             ls_ok
);
  localparam int CMP_W = (CNT_W > LST_W) ? CNT_W : LST_W;

  logic [CMP_W-1:0] rem_x, lst_x;
  assign rem_x = CMP_W'(remain);
  assign lst_x = CMP_W'(lsthr);

  always_ff @(posedge clk) begin
    if (rst) begin
      periodic_pri <= 1'b0;
      ls_ok        <= 1'b0;
    end else begin
      periodic_pri <= (remain <= pstart);
      ls_ok        <= (rem_x > lst_x);
    end
  end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import usb_frm_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int MPS_W   = 15,
  parameter int LST_W   = 15,
  parameter int NUM_W   = 16,
  parameter int FI_INIT = 11999
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             bit_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] interval_rd,
  output logic [REG_W-1:0] pstart_rd,
  output logic [REG_W-1:0] lsthr_rd,
  output logic [REG_W-1:0] remain_rd,
  output logic [NUM_W-1:0] frame_num,
  output logic             sof_pulse,
  output logic             fno_pulse,
  output logic             periodic_pri,
  output logic             ls_ok
);
  localparam int GAP_W = REG_W - 1 - MPS_W - CNT_W;
  localparam int REM_PAD = REG_W - 1 - CNT_W;

  logic [CNT_W-1:0] fi, pstart, remain;
  logic [MPS_W-1:0] mps;
  logic [LST_W-1:0] lsthr;
  logic             tog, rem_tog;

  frm_regs #(.CNT_W(CNT_W), .MPS_W(MPS_W), .LST_W(LST_W), .FI_INIT(FI_INIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fi(fi), .mps(mps), .tog(tog), .pstart(pstart), .lsthr(lsthr)
  );

  frm_count #(.CNT_W(CNT_W), .NUM_W(NUM_W)) u_count (
    .clk(clk), .rst(rst), .run_en(run_en), .bit_tick(bit_tick),
    .fi(fi), .tog(tog), .remain(remain), .rem_tog(rem_tog),
    .fnum(frame_num), .sof(sof_pulse), .fno(fno_pulse)
  );

  frm_cmp #(.CNT_W(CNT_W), .LST_W(LST_W)) u_cmp (
    .clk(clk), .rst(rst), .remain(remain), .pstart(pstart), .lsthr(lsthr),
    .periodic_pri(periodic_pri), .ls_ok(ls_ok)
  );

  assign interval_rd = {tog, mps, {GAP_W{1'b0}}, fi};
  assign pstart_rd   = {{(REG_W-CNT_W){1'b0}}, pstart};
  assign lsthr_rd    = {{(REG_W-LST_W){1'b0}}, lsthr};
  assign remain_rd   = {rem_tog, {REM_PAD{1'b0}}, remain};
endmodule

// File: rtl/usb_frame_timer_chk.sv
module usb_frame_timer_chk (
  input logic        clk,
  input logic        rst,
  input logic        run_en,
  input logic        bit_tick,
  input logic [13:0] interval_fi,
  input logic [31:0] remain_rd,
  input logic [15:0] frame_num,
  input logic        sof_pulse,
  input logic        fno_pulse
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R4: a reload takes the frame length held in the previous cycle
  assert_reload_len_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    sof_pulse |-> remain_rd[13:0] == $past(interval_fi));

  // R5: every start of frame advances the frame number by one
  assert_sof_advance_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    sof_pulse |-> frame_num == $past(frame_num) + 16'd1);

  // R6: overflow strobe only comes with a new frame
  assert_fno_with_sof_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    fno_pulse |-> sof_pulse);

  // R6: a change of bit 15 is always flagged
  assert_fno_on_msb_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    (frame_num[15] != $past(frame_num[15])) |-> fno_pulse);

  // R9: no counting while not operational
  assert_hold_stopped_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(run_en) |-> ($stable(remain_rd) && $stable(frame_num) && !sof_pulse));

  // R4: no change without a tick
  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(bit_tick) |-> ($stable(remain_rd) && $stable(frame_num)));
endmodule

bind usb_frame_timer usb_frame_timer_chk u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .bit_tick(bit_tick),
  .interval_fi(interval_rd[13:0]), .remain_rd(remain_rd),
  .frame_num(frame_num), .sof_pulse(sof_pulse), .fno_pulse(fno_pulse)
);

// File: tb/usb_frame_timer_test.sv
module usb_frame_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0, bit_tick = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] interval_rd, pstart_rd, lsthr_rd, remain_rd;
  logic [15:0] frame_num;
  logic        sof_pulse, fno_pulse, periodic_pri, ls_ok;

  int n_tests = 0, n_fail = 0, cycles = 0;

  always #10 clk = ~clk;

  usb_frame_timer uut (
    .clk(clk), .rst(rst), .run_en(run_en), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .interval_rd(interval_rd),
    .pstart_rd(pstart_rd), .lsthr_rd(lsthr_rd), .remain_rd(remain_rd),
    .frame_num(frame_num), .sof_pulse(sof_pulse), .fno_pulse(fno_pulse),
    .periodic_pri(periodic_pri), .ls_ok(ls_ok)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bit_tick = 1'b0; wr_en = 1'b0;
    step(); step(); step();
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk); rst = 1'b1; step(); step();
    check("R1 interval", interval_rd, 32'h0000_2EDF);
    check("R1 pstart", pstart_rd, 32'h0);
    check("R1 lsthr", lsthr_rd, 32'h0);
    check("R1 remain", remain_rd, 32'h0);
    check("R1 frame", {16'h0, frame_num}, 32'h0);
    check("R1 outputs", {28'h0, sof_pulse, fno_pulse, periodic_pri, ls_ok}, 32'h0);
    rst = 1'b0;
  endtask

  task automatic test_regs();
    wr(2'd0, 32'hFFFF_FFFF);
    check("R2 interval fields", interval_rd, 32'hFFFF_3FFF);
    wr(2'd1, 32'hFFFF_FFFF);
    check("R3 pstart mask", pstart_rd, 32'h0000_3FFF);
    wr(2'd2, 32'hFFFF_FFFF);
    check("R3 lsthr mask", lsthr_rd, 32'h0000_7FFF);
    wr(2'd3, 32'h0000_0000);
    check("R3 sel3 ignored", interval_rd ^ pstart_rd ^ lsthr_rd,
          32'hFFFF_3FFF ^ 32'h3FFF ^ 32'h7FFF);
    wr(2'd0, 32'h8123_0005);
    check("R2 interval value", interval_rd, 32'h8123_0005);
  endtask

  task automatic test_count();
    run_en = 1'b1;
    tick();
    check("R4 first reload", remain_rd, 32'h8000_0005);
    check("R5 sof high", {31'h0, sof_pulse}, 32'h1);
    check("R5 frame 1", {16'h0, frame_num}, 32'h1);
    tick();
    check("R4 decrement", remain_rd, 32'h8000_0004);
    check("R5 sof one clock", {31'h0, sof_pulse}, 32'h0);
    for (int i = 0; i < 4; i++) tick();
    check("R4 reach zero", remain_rd, 32'h8000_0000);
    tick();
    check("R4 second reload", remain_rd, 32'h8000_0005);
    check("R5 frame 2", {16'h0, frame_num}, 32'h2);
    run_en = 1'b0;
    for (int i = 0; i < 3; i++) tick();
    check("R9 count held", remain_rd, 32'h8000_0005);
    check("R9 frame held", {16'h0, frame_num}, 32'h2);
    run_en = 1'b1;
    tick();
    check("R9 resumes", remain_rd, 32'h8000_0004);
  endtask

  task automatic test_midframe();
    wr(2'd0, 32'h0000_0003);
    check("R10 no early load", remain_rd, 32'h8000_0004);
    for (int i = 0; i < 4; i++) tick();
    check("R10 old frame finishes", remain_rd, 32'h8000_0000);
    tick();
    check("R10 new length and toggle", remain_rd, 32'h0000_0003);
    check("R5 frame 3", {16'h0, frame_num}, 32'h3);
  endtask

  task automatic test_thresholds();
    wr(2'd1, 32'h2);
    wr(2'd2, 32'h2);
    step(); step();
    check("R7 above pstart", {31'h0, periodic_pri}, 32'h0);
    check("R8 above lsthr", {31'h0, ls_ok}, 32'h1);
    tick(); step();
    check("R7 equal pstart", {31'h0, periodic_pri}, 32'h1);
    check("R8 equal lsthr", {31'h0, ls_ok}, 32'h0);
    tick(); step();
    check("R7 below pstart", {31'h0, periodic_pri}, 32'h1);
    check("R8 below lsthr", {31'h0, ls_ok}, 32'h0);
  endtask

  task automatic test_overflow();
    int hits = 0;
    logic [15:0] at0 = 16'hDEAD, at1 = 16'hDEAD;
    do_reset();
    wr(2'd0, 32'h0);
    run_en = 1'b1;
    @(negedge clk); bit_tick = 1'b1;
    for (int i = 1; i <= 65536; i++) begin
      @(negedge clk);
      if (fno_pulse) begin
        if (hits == 0) at0 = frame_num; else at1 = frame_num;
        hits++;
      end
    end
    bit_tick = 1'b0;
    check("R6 pulse count", hits, 32'd2);
    check("R6 first at 0x8000", {16'h0, at0}, 32'h8000);
    check("R6 second at wrap", {16'h0, at1}, 32'h0);
    check("R5 frame wraps", {16'h0, frame_num}, 32'h0);
  endtask

  initial begin
    test_reset();
    do_reset();
    test_regs();
    test_count();
    test_midframe();
    test_thresholds();
    test_overflow();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule